// File: doc/BRIEF.md
# ADC Sample-and-Convert Sequencer

This block runs the sample-then-convert cycle of a 12-bit successive-approximation converter. Software drives it through one 16-bit control word. The word holds an enable, a stop-when-idle option, a result format, a choice of the event that closes the sampling window, an auto-restart option, a live sample flag and a completion flag. While sampling is open, the selected event closes the window. The block then strobes a converter model, which returns a 12-bit code after a fixed number of cycles. The block packs that code into a 16-bit result word.

The event that ends sampling can be one of five: a software write, a rising edge on an asynchronous pin, a timer-compare pulse, an end-of-PWM-interval pulse, or an internal window counter. With auto-restart set, a new sampling window opens as soon as each conversion completes, so only the end event paces the conversions. Clearing the enable, or entering idle while stop-when-idle is set, aborts any activity at once and leaves the last result and the completion flag intact.

Top module: `adcseq_top`

## Requirements
- R1: Control word fields: bit 15 enable, bit 13 stop-when-idle, bits 9:8 format, bits 7:5 end-event code, bit 2 auto-restart, bit 1 sample (reads 1 exactly while sampling), bit 0 done. Bits 14, 12:10 and 4:3 read 0. Everything reads 0 after reset.
- R2: A write with bit 1 = 1 while enabled and idle opens sampling, and bit 1 reads 1 in the next cycle. Under code 000, a write with bit 1 = 0 while sampling raises `conv_o` in the next cycle. Under any other code, that write leaves sampling open.
- R3: Code 001: `pin_trig_i` passes two synchronising flops and a rising-edge detector. A rise first seen in cycle t raises `conv_o` in cycle t+3.
- R4: A `tmr_cmp_i` pulse in cycle t under code 010, or a `pwm_end_i` pulse under code 011, raises `conv_o` in cycle t+1. The other pulse is ignored.
- R5: Codes 100, 101 and 110 never end sampling.
- R6: Code 111: sampling lasts SAMP_CYC cycles (default 31). If bit 1 first reads 1 in cycle s, `conv_o` is high in cycle s+SAMP_CYC.
- R7: `conv_o` is a one-cycle pulse. `hold_o` is high from that cycle c through c+14. The done flag and `result_o` update in cycle c+15, because the converter model latches `analog_i` at the strobe and answers 14 cycles later.
- R8: Done is set by completion and cleared in the cycle `conv_o` rises. A write of 0 to bit 0 clears it without disturbing a running conversion. A write of 1 to bit 0 leaves it unchanged.
- R9: With auto-restart set, sample reads 1 in the same cycle that done rises. With it clear, sample reads 0 in that cycle.
- R10: Format 00 places the code in bits 11:0 with zeros above. Format 01 sign-extends from code bit 11. Formats 10 and 11 both place the code in bits 15:4 with four zero LSBs; format 11 reads that pattern as two's complement.
- R11: End events that arrive while not sampling are ignored, as are events during a conversion. A write of 1 to bit 1 during a conversion has no effect.
- R12: A write that clears enable returns the sequencer to idle by the next cycle, with sample and `hold_o` at 0. Done and `result_o` keep their values, and a conversion that was running is discarded. Writes of 1 to bit 1 while disabled are ignored.
- R13: While stop-when-idle is 1, `idle_i` high ends sampling in the next cycle. While it is 0, `idle_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_i | input | 1 | Control word write strobe |
| reg_wdata_i | input | 16 | Control word write data |
| reg_rdata_o | output | 16 | Control word read value |
| idle_i | input | 1 | System idle indication |
| pin_trig_i | input | 1 | Asynchronous external trigger pin |
| tmr_cmp_i | input | 1 | Timer-compare pulse |
| pwm_end_i | input | 1 | PWM interval end pulse |
| analog_i | input | 12 | Code presented to the converter model |
| hold_o | output | 1 | High while a conversion holds the sample |
| conv_o | output | 1 | Start-conversion strobe |
| result_o | output | 16 | Formatted conversion result |

## Verification
Every result has a fixed due cycle:
- a register write shows in the next cycle;
- `conv_o` follows a pulse event by one cycle, a pin rise by three, and the first sampling cycle by SAMP_CYC in auto mode;
- done and the result follow `conv_o` by fifteen.

The bench records a free-running posedge count when each stimulus is applied. It waits until that count reaches the due value and samples on the falling edge. It also checks the cycle just before the due one, so an early result is caught as well as a late one. A sweep covers all four formats against boundary and spread codes, with expected words computed arithmetically.

// File: rtl/adcseq_pkg.sv
// Package: shared constants and types of the ADC sample-and-convert sequencer.
// Assumes a 12-bit raw code and a 16-bit control/result word.
package adcseq_pkg;

    localparam int RAW_W  = 12;
    localparam int WORD_W = 16;

    // Control word bit positions (software-visible layout)
    localparam int BIT_EN   = 15;
    localparam int BIT_SIDL = 13;
    localparam int FMT_LO   = 8;
    localparam int TRG_LO   = 5;
    localparam int BIT_ASAM = 2;
    localparam int BIT_SAMP = 1;
    localparam int BIT_DONE = 0;

    // End-event codes
    localparam logic [2:0] TRG_SOFT = 3'b000;
    localparam logic [2:0] TRG_PIN  = 3'b001;
    localparam logic [2:0] TRG_TMR  = 3'b010;
    localparam logic [2:0] TRG_PWM  = 3'b011;
    localparam logic [2:0] TRG_AUTO = 3'b111;

    // Result formats
    localparam logic [1:0] FMT_UINT  = 2'b00;
    localparam logic [1:0] FMT_SINT  = 2'b01;
    localparam logic [1:0] FMT_UFRAC = 2'b10;
    localparam logic [1:0] FMT_SFRAC = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SAMP = 2'd1,
        ST_CONV = 2'd2
    } seq_st_e;

    typedef struct packed {
        logic       en;
        logic       sidl;
        logic [1:0] fmt;
        logic [2:0] trg;
        logic       asam;
    } cfg_t;

endpackage

// File: rtl/adcseq_pin_sync.sv
// Module: two-flop (parameterised) synchroniser plus rising-edge detector for
// an asynchronous trigger pin. Assumes the pin stays high for at least one cycle.
module adcseq_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);

    logic [STAGES:0] shreg_q;

    // Shift the pin through the synchroniser and one delay stage
    always_ff @(posedge clk) begin
        if (!rst_n) shreg_q <= '0;
        else        shreg_q <= {shreg_q[STAGES-1:0], pin_i};
    end

    assign rise_o = shreg_q[STAGES-1] & ~shreg_q[STAGES];

    // R3: a detected rise lasts one cycle
    a_r3_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/adcseq_trig_sel.sv
// Module: chooses the event that closes the sampling window. It holds the
// pin synchroniser and the auto-convert window counter. Assumes sampling_i
// is high exactly while the sequencer samples; events outside it are dropped.
module adcseq_trig_sel
    import adcseq_pkg::*;
#(
    parameter int SAMP_CYC    = 31,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] trg_i,
    input  logic       sampling_i,
    input  logic       sw_end_i,
    input  logic       pin_i,
    input  logic       tmr_i,
    input  logic       pwm_i,
    output logic       end_o
);

    localparam int CNT_W = $clog2(SAMP_CYC + 1);

    logic             pin_rise;
    logic [CNT_W-1:0] win_cnt_q;
    logic             win_full;
    logic             sel_evt;

    adcseq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .rise_o (pin_rise)
    );

    // Count sampling cycles; restart whenever sampling is closed
    always_ff @(posedge clk) begin
        if (!rst_n || !sampling_i)  win_cnt_q <= '0;
        else if (!win_full)         win_cnt_q <= win_cnt_q + 1'b1;
    end

    assign win_full = (win_cnt_q == CNT_W'(SAMP_CYC - 1));

    // Pick the event source for the current code
    always_comb begin
        case (trg_i)
            TRG_SOFT: sel_evt = sw_end_i;
            TRG_PIN:  sel_evt = pin_rise;
            TRG_TMR:  sel_evt = tmr_i;
            TRG_PWM:  sel_evt = pwm_i;
            TRG_AUTO: sel_evt = win_full;
            default:  sel_evt = 1'b0;
        endcase
    end

    assign end_o = sampling_i & sel_evt;

    // R5: reserved codes never close the window
    a_r5_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (trg_i == 3'b100 || trg_i == 3'b101 || trg_i == 3'b110) |-> !end_o);

    // R6: in auto mode the window never closes before its count is reached
    a_r6_auto_not_early: assert property (@(posedge clk) disable iff (!rst_n)
        (end_o && trg_i == TRG_AUTO) |-> (win_cnt_q >= CNT_W'(SAMP_CYC - 1)));

endmodule

// File: rtl/adcseq_conv_stub.sv
// Module: behavioural stand-in for the SAR converter. It latches the input
// code on the start strobe and presents it with a one-cycle valid exactly
// CONV_LAT cycles later. A new start reloads it. Assumes CONV_LAT >= 2.
module adcseq_conv_stub #(
    parameter int CONV_LAT = 14,
    parameter int RAW_W    = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [RAW_W-1:0] sample_i,
    output logic             valid_o,
    output logic [RAW_W-1:0] data_o
);

    localparam int CW = $clog2(CONV_LAT + 1);

    logic [CW-1:0]    cnt_q;
    logic [RAW_W-1:0] data_q;

    // Load the latency counter on start, count it down otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (start_i)        cnt_q <= CW'(CONV_LAT);
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    // Capture the presented code at the start strobe
    always_ff @(posedge clk) begin
        if (!rst_n)        data_q <= '0;
        else if (start_i)  data_q <= sample_i;
    end

    assign valid_o = (cnt_q == CW'(1));
    assign data_o  = data_q;

    // R7: the answer is a single-cycle pulse
    a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

endmodule

// File: rtl/adcseq_fmt.sv
// Module: packs a raw code into the result word in one of four layouts.
// Purely combinational. Assumes WORD_W > RAW_W.
module adcseq_fmt
    import adcseq_pkg::*;
#(
    parameter int RAW_W  = 12,
    parameter int WORD_W = 16
) (
    input  logic [1:0]        fmt_i,
    input  logic [RAW_W-1:0]  raw_i,
    output logic [WORD_W-1:0] word_o
);

    localparam int PAD_W = WORD_W - RAW_W;

    // Select the packing for the chosen format
    always_comb begin
        case (fmt_i)
            FMT_UINT: word_o = {{PAD_W{1'b0}}, raw_i};
            FMT_SINT: word_o = {{PAD_W{raw_i[RAW_W-1]}}, raw_i};
            default:  word_o = {raw_i, {PAD_W{1'b0}}};
        endcase
    end

    // R10: layout properties of the packed word
    always_comb begin
        if (fmt_i == FMT_UINT)
            a_r10_uint_top_zero: assert (word_o[WORD_W-1:RAW_W] == '0);
        if (fmt_i == FMT_UFRAC || fmt_i == FMT_SFRAC)
            a_r10_frac_low_zero: assert (word_o[PAD_W-1:0] == '0);
    end

endmodule

// File: rtl/adcseq_top.sv
// Module: sample-and-convert sequencer top. It holds the control word, runs
// the idle/sample/convert state machine, strobes the converter model and
// stores the formatted result. Assumes synchronous active-low reset.
// Control writes take effect at the next edge.
module adcseq_top
    import adcseq_pkg::*;
#(
    parameter int CONV_LAT    = 14,
    parameter int SAMP_CYC    = 31,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic [WORD_W-1:0] reg_wdata_i,
    output logic [WORD_W-1:0] reg_rdata_o,
    input  logic              idle_i,
    input  logic              pin_trig_i,
    input  logic              tmr_cmp_i,
    input  logic              pwm_end_i,
    input  logic [RAW_W-1:0]  analog_i,
    output logic              hold_o,
    output logic              conv_o,
    output logic [WORD_W-1:0] result_o
);

    cfg_t              cfg_q, cfg_d;
    seq_st_e           st_q, st_d;
    logic              done_q, done_d;
    logic              conv_q, conv_d;
    logic [WORD_W-1:0] res_q;

    logic              sampling, halted, end_evt, sw_end;
    logic              stub_valid, conv_done;
    logic [RAW_W-1:0]  stub_data;
    logic [WORD_W-1:0] fmt_word;
    logic              unused_wbits;

    assign unused_wbits = ^{reg_wdata_i[14], reg_wdata_i[12:10], reg_wdata_i[4:3]};

    // Next configuration: the written fields, or the held ones
    always_comb begin
        if (reg_wr_i)
            cfg_d = '{en:   reg_wdata_i[BIT_EN],
                      sidl: reg_wdata_i[BIT_SIDL],
                      fmt:  reg_wdata_i[FMT_LO +: 2],
                      trg:  reg_wdata_i[TRG_LO +: 3],
                      asam: reg_wdata_i[BIT_ASAM]};
        else
            cfg_d = cfg_q;
    end

    assign sampling  = (st_q == ST_SAMP);
    assign halted    = ~cfg_d.en | (cfg_d.sidl & idle_i);
    assign sw_end    = reg_wr_i & ~reg_wdata_i[BIT_SAMP];
    assign conv_done = stub_valid & (st_q == ST_CONV);

    adcseq_trig_sel #(.SAMP_CYC(SAMP_CYC), .SYNC_STAGES(SYNC_STAGES)) u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .trg_i      (cfg_q.trg),
        .sampling_i (sampling),
        .sw_end_i   (sw_end),
        .pin_i      (pin_trig_i),
        .tmr_i      (tmr_cmp_i),
        .pwm_i      (pwm_end_i),
        .end_o      (end_evt)
    );

    adcseq_conv_stub #(.CONV_LAT(CONV_LAT), .RAW_W(RAW_W)) u_stub (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (conv_q),
        .sample_i (analog_i),
        .valid_o  (stub_valid),
        .data_o   (stub_data)
    );

    adcseq_fmt #(.RAW_W(RAW_W), .WORD_W(WORD_W)) u_fmt (
        .fmt_i  (cfg_q.fmt),
        .raw_i  (stub_data),
        .word_o (fmt_word)
    );

    // Sequencer state transitions and start-conversion request
    always_comb begin
        st_d   = st_q;
        conv_d = 1'b0;
        if (halted) begin
            st_d = ST_IDLE;
        end else begin
            case (st_q)
                ST_IDLE: if (reg_wr_i && reg_wdata_i[BIT_SAMP]) st_d = ST_SAMP;
                ST_SAMP: if (end_evt) begin
                    st_d   = ST_CONV;
                    conv_d = 1'b1;
                end
                ST_CONV: if (conv_done) st_d = cfg_q.asam ? ST_SAMP : ST_IDLE;
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // Done flag: set on completion, cleared by a new start or a software zero
    always_comb begin
        if (conv_done)                             done_d = 1'b1;
        else if (conv_d)                           done_d = 1'b0;
        else if (reg_wr_i && !reg_wdata_i[BIT_DONE]) done_d = 1'b0;
        else                                       done_d = done_q;
    end

    // State, configuration and strobe registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            st_q   <= ST_IDLE;
            done_q <= 1'b0;
            conv_q <= 1'b0;
        end else begin
            cfg_q  <= cfg_d;
            st_q   <= st_d;
            done_q <= done_d;
            conv_q <= conv_d;
        end
    end

    // Result register, loaded only by a completion the sequencer waits for
    always_ff @(posedge clk) begin
        if (!rst_n)         res_q <= '0;
        else if (conv_done) res_q <= fmt_word;
    end

    // Control word read-back
    always_comb begin
        reg_rdata_o           = '0;
        reg_rdata_o[BIT_EN]   = cfg_q.en;
        reg_rdata_o[BIT_SIDL] = cfg_q.sidl;
        reg_rdata_o[FMT_LO +: 2] = cfg_q.fmt;
        reg_rdata_o[TRG_LO +: 3] = cfg_q.trg;
        reg_rdata_o[BIT_ASAM] = cfg_q.asam;
        reg_rdata_o[BIT_SAMP] = sampling;
        reg_rdata_o[BIT_DONE] = done_q;
    end

    assign hold_o   = (st_q == ST_CONV);
    assign conv_o   = conv_q;
    assign result_o = res_q;

    // R7: the start strobe coincides with holding
    a_r7_conv_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        conv_q |-> hold_o);

    // R11: a start only follows a cycle of sampling
    a_r11_conv_after_samp: assert property (@(posedge clk) disable iff (!rst_n)
        conv_q |-> ($past(st_q) == ST_SAMP));

    // R12: a disabled module sits idle
    a_r12_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.en |-> (st_q == ST_IDLE));

    // R12: result kept while disabled
    a_r12_result_kept: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!cfg_q.en) |-> $stable(res_q));

    // R8: done only rises out of a conversion
    a_r8_done_from_conv: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> ($past(st_q) == ST_CONV));

endmodule

// File: tb/adcseq_top_tb.sv
// Bench for adcseq_top: directed timing checks plus a format sweep.
// Inputs change and outputs are sampled on falling edges.
module adcseq_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [15:0] wd = '0;
    logic [15:0] rd;
    logic        idle = 1'b0, pin = 1'b0, tmr = 1'b0, pwm = 1'b0;
    logic [11:0] ana = '0;
    logic        hold, conv;
    logic [15:0] res;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit finished = 0;

    localparam logic [15:0] SIDL  = 16'h2000;
    localparam logic [15:0] ASAM  = 16'h0004;
    localparam logic [15:0] SAMPB = 16'h0002;
    localparam logic [15:0] DONEB = 16'h0001;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    adcseq_top u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(wr), .reg_wdata_i(wd),
        .reg_rdata_o(rd), .idle_i(idle), .pin_trig_i(pin),
        .tmr_cmp_i(tmr), .pwm_end_i(pwm), .analog_i(ana),
        .hold_o(hold), .conv_o(conv), .result_o(res)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr16(input logic [15:0] d);
        wr = 1'b1; wd = d;
        tick();
        wr = 1'b0;
    endtask

    task automatic wait_to(input int n);
        while (cyc < n) tick();
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] cw(input int f, input int t);
        return 16'h8000 | 16'(f << 8) | 16'(t << 5);
    endfunction

    function automatic logic [15:0] expfmt(input int f, input int raw);
        int v;
        case (f)
            0: v = raw;
            1: v = (raw >= 2048) ? raw + 61440 : raw;
            default: v = raw * 16;
        endcase
        return 16'(v);
    endfunction

    function automatic int pick(input int i);
        case (i)
            0: return 0;
            1: return 12'h7FF;
            2: return 12'h800;
            3: return 12'hFFF;
            4: return 1;
            default: return (i * 409 + i * i * 13) % 4096;
        endcase
    endfunction

    // After conv observed in cycle c0, check the completion timing and result
    task automatic finish_conv(input int c0, input int f, input int raw, input logic asam);
        wait_to(c0 + 14);
        chk("R7 hold high, done low before due", {30'd0, hold, rd[0]}, 32'b10);
        tick();
        chk("R7 done due at conv+15, hold low", {30'd0, hold, rd[0]}, 32'b01);
        chk("R10 formatted result", res, expfmt(f, raw));
        chk("R9 sample after done", rd[1], asam);
    endtask

    task automatic do_conv(input int f, input int raw);
        int c0;
        ana = 12'(raw);
        wr16(cw(f, 0) | SAMPB);
        chk("R2 sample opens", rd[1], 1);
        wr16(cw(f, 0));
        chk("R2 soft end raises conv", conv, 1);
        chk("R8 done cleared at start", rd[0], 0);
        c0 = cyc;
        finish_conv(c0, f, raw, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int c0, d1;
        logic [15:0] keep;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R1 reset word", rd, 16'h0000);
        chk("R1 reset result/strobes", {res, 14'd0, hold, conv}, 32'd0);

        // R1 unused bits and field placement
        wr16(16'h7C18);
        chk("R1 unused bits read zero", rd, 16'h2000);
        wr16(16'h8264);
        chk("R1 field placement", rd, 16'h8264);
        wr16(16'h0000);

        // R10 sweep over formats and codes (also R2, R7, R8, R9)
        for (int f = 0; f < 4; f++)
            for (int i = 0; i < 36; i++)
                do_conv(f, pick(i));

        // R2: software zero ignored under a non-soft code
        ana = 12'h3A5;
        wr16(cw(1, 2) | SAMPB);
        wr16(cw(1, 2));
        chk("R2 zero write ignored under code 010", {30'd0, rd[1], conv}, 32'b10);
        // R4 timer pulse
        tmr = 1'b1; tick(); tmr = 1'b0;
        chk("R4 timer pulse starts conv", conv, 1);
        c0 = cyc;
        tick();
        // R11 events and sample writes during conversion
        tmr = 1'b1; tick(); tmr = 1'b0;
        chk("R11 timer during conversion ignored", conv, 0);
        wr16(cw(1, 2) | SAMPB | DONEB);
        chk("R11 sample write during conversion ignored", rd[1], 0);
        finish_conv(c0, 1, 12'h3A5, 1'b0);

        // R11 pulse while not sampling, then R4 pwm vs timer
        pwm = 1'b1; tick(); pwm = 1'b0;
        chk("R11 pulse while idle ignored", {30'd0, conv, rd[1]}, 32'd0);
        ana = 12'hC3C;
        wr16(cw(0, 3) | SAMPB);
        tmr = 1'b1; tick(); tmr = 1'b0;
        chk("R4 timer ignored under code 011", conv, 0);
        pwm = 1'b1; tick(); pwm = 1'b0;
        chk("R4 pwm pulse starts conv", conv, 1);
        c0 = cyc;
        finish_conv(c0, 0, 12'hC3C, 1'b0);

        // R3 pin path latency
        ana = 12'h812;
        wr16(cw(2, 1) | SAMPB);
        pin = 1'b1;
        tick(); chk("R3 no conv at t+1", conv, 0);
        tick(); chk("R3 no conv at t+2", conv, 0);
        tick(); chk("R3 conv at t+3", conv, 1);
        c0 = cyc;
        finish_conv(c0, 2, 12'h812, 1'b0);
        pin = 1'b0;

        // R5 reserved codes
        for (int t = 4; t < 7; t++) begin
            int hits;
            hits = 0;
            wr16(cw(0, t) | SAMPB | DONEB);
            tmr = 1'b1; pwm = 1'b1; pin = 1'b1; tick();
            tmr = 1'b0; pwm = 1'b0; tick();
            if (conv) hits++;
            wr16(cw(0, t) | DONEB);
            for (int k = 0; k < 40; k++) begin
                if (conv) hits++;
                tick();
            end
            pin = 1'b0;
            chk("R5 reserved code never ends sampling", {31'd0, rd[1]} | 32'(hits << 1), 1);
            wr16(DONEB);
        end

        // R6 auto window and R9 auto-restart
        ana = 12'h5A0;
        wr16(cw(3, 7) | ASAM | SAMPB);
        c0 = cyc;
        wait_to(c0 + 30);
        chk("R6 no conv before window end", conv, 0);
        tick();
        chk("R6 conv at window end", conv, 1);
        finish_conv(cyc, 3, 12'h5A0, 1'b1);
        d1 = cyc;
        wait_to(d1 + 30);
        chk("R6 rearmed window not early", conv, 0);
        tick();
        chk("R9 R6 rearmed window conv", conv, 1);
        finish_conv(cyc, 3, 12'h5A0, 1'b1);

        // R12 disable while sampling keeps done and result
        keep = res;
        wr16(DONEB);
        chk("R12 idle, done kept after disable", rd, 16'h0001);
        chk("R12 hold low after disable", hold, 0);
        wr16(SAMPB | DONEB);
        chk("R12 sample write while disabled ignored", rd, 16'h0001);
        chk("R12 result kept", res, keep);

        // R12 disable during conversion discards it
        ana = 12'h111;
        wr16(cw(0, 0) | SAMPB);
        wr16(cw(0, 0));
        chk("R12 conversion started", conv, 1);
        wr16(DONEB);
        repeat (20) tick();
        chk("R12 aborted conversion leaves done", rd, 16'h0000);
        chk("R12 aborted conversion leaves result", res, keep);

        // R8 done write semantics
        wr16(16'h8000 | DONEB);
        chk("R8 write of 1 does not set done", rd[0], 0);
        do_conv(0, 12'h0F0);
        wr16(16'h8000 | DONEB);
        chk("R8 write of 1 keeps done", rd[0], 1);
        wr16(16'h8000);
        chk("R8 write of 0 clears done", rd[0], 0);
        ana = 12'h0AB;
        wr16(cw(0, 0) | SAMPB);
        wr16(cw(0, 0));
        c0 = cyc;
        tick(); tick();
        wr16(cw(0, 0));
        chk("R8 clear during conversion keeps hold", hold, 1);
        finish_conv(c0, 0, 12'h0AB, 1'b0);

        // R13 stop-when-idle
        wr16(cw(0, 0) | SIDL | SAMPB);
        idle = 1'b1; tick();
        chk("R13 idle stops sampling", rd[1], 0);
        idle = 1'b0;
        ana = 12'h777;
        wr16(cw(0, 0) | SAMPB);
        idle = 1'b1;
        repeat (5) tick();
        chk("R13 idle ignored without stop bit", rd[1], 1);
        wr16(cw(0, 0));
        chk("R13 conversion proceeds in idle", conv, 1);
        finish_conv(cyc, 0, 12'h777, 1'b0);
        idle = 1'b0;

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule